// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This combinational unit sits beside the decode stage of an in-order five-stage integer pipeline. It compares the two source register indices of the instruction being decoded against the destination indices of the three older instructions held in the execute, memory and write-back stages. For each source operand it produces a 2-bit select. The operand multiplexers in front of the ID/EX operand registers use that select to take the value from the register file or from one of the three later stages.

When the instruction in execute is a load whose destination is needed by the decoding instruction, the loaded data does not exist yet. The unit then raises a stall, which holds the program counter and instruction register, and a bubble, which clears the control word entering execute. One cycle later the load has reached the memory stage and its data is forwarded from there. Instructions two or more places behind a load are served by forwarding alone.

Top module: `fwd_stall_unit`

## Requirements
- R1: The select encoding is 2'd0 for the register file, 2'd1 for the execute stage, 2'd2 for the memory stage and 2'd3 for the write-back stage. With no stage matching, both selects are 2'd0 and stall and bubble are 0.
- R2: When the execute stage matches a source, its select is 2'd1, even if the memory and write-back stages match as well.
- R3: When the memory stage matches and the execute stage does not, the select is 2'd2, even if the write-back stage also matches.
- R4: A source index of zero never produces a forward, even when a stage with write enable set has destination zero.
- R5: A stage whose write enable is 0 never produces a forward, even when its destination equals the source.
- R6: The select for operand A depends only on the rs source, and the select for operand B depends only on the rt source. Both follow the same rules, and each is evaluated independently.
- R7: stall is 1 exactly when the execute-stage load flag is 1 and at least one select equals 2'd1.
- R8: bubble equals stall in every cycle.
- R9: A load in the memory stage that matches a source gives select 2'd2 with no stall.
- R10: While stall is 1, the selects still show the execute-stage match. They are recomputed from the inputs of the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rs_i | input | REG_AW | First source register index of the decoding instruction |
| rt_i | input | REG_AW | Second source register index of the decoding instruction |
| ex_rd_i | input | REG_AW | Destination index in the execute stage |
| mem_rd_i | input | REG_AW | Destination index in the memory stage |
| wb_rd_i | input | REG_AW | Destination index in the write-back stage |
| ex_we_i | input | 1 | Register write enable in the execute stage |
| mem_we_i | input | 1 | Register write enable in the memory stage |
| wb_we_i | input | 1 | Register write enable in the write-back stage |
| ex_load_i | input | 1 | Execute-stage instruction reads data memory |
| fwd_a_o | output | 2 | Select for operand A |
| fwd_b_o | output | 2 | Select for operand B |
| stall_o | output | 1 | Hold program counter and instruction register |
| bubble_o | output | 1 | Clear the control word entering execute |

## Verification
The hardest situation to reach from the ports is a source that matches all three stages at once while one of those stages is ineligible. Examples are write enable dropped at the nearest stage, or a zero index that every stage also targets. A wrong priority or a missing qualifier only shows up in that case. The directed scenarios build these overlaps on purpose. They also walk a load from execute to memory over two consecutive cycles, to see the stall rise and then clear with the select moving from 1 to 2.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned NUM_STAGES = 3;  // EX, MEM, WB, nearest first
  localparam int unsigned NUM_SRCS   = 2;  // rs, rt

  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_EX  = 2'd1,
    FWD_MEM = 2'd2,
    FWD_WB  = 2'd3
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] dst_i,
  input  logic              we_i,
  output logic              hit_o
);
  logic src_nz;
  assign src_nz = |src_i;
  assign hit_o  = we_i & src_nz & (src_i == dst_i);

  always_comb begin
    if (hit_o) begin
      assert_hit_src_nonzero_R4: assert (src_i != '0);
      assert_hit_needs_we_R5:    assert (we_i);
    end
  end
endmodule

// File: rtl/fwd_prio.sv
module fwd_prio
  import fwd_pkg::*;
(
  input  logic [NUM_STAGES-1:0] hit_i,  // bit0 EX, bit1 MEM, bit2 WB
  output fwd_sel_e              sel_o
);
  always_comb begin
    if (hit_i[0])      sel_o = FWD_EX;
    else if (hit_i[1]) sel_o = FWD_MEM;
    else if (hit_i[2]) sel_o = FWD_WB;
    else               sel_o = FWD_RF;
  end

  always_comb begin
    if (hit_i[0]) assert_ex_wins_R2: assert (sel_o == FWD_EX);
    if (!hit_i[0] && hit_i[1]) assert_mem_over_wb_R3: assert (sel_o == FWD_MEM);
    if (hit_i == '0) assert_idle_rf_R1: assert (sel_o == FWD_RF);
  end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect
  import fwd_pkg::*;
(
  input  logic     ex_load_i,
  input  fwd_sel_e sel_a_i,
  input  fwd_sel_e sel_b_i,
  output logic     stall_o
);
  assign stall_o = ex_load_i & ((sel_a_i == FWD_EX) | (sel_b_i == FWD_EX));

  always_comb begin
    if (stall_o) assert_stall_needs_load_R7: assert (ex_load_i);
  end
endmodule

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit
  import fwd_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] rs_i,
  input  logic [REG_AW-1:0] rt_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              ex_we_i,
  input  logic              mem_we_i,
  input  logic              wb_we_i,
  input  logic              ex_load_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic              stall_o,
  output logic              bubble_o
);
  logic [REG_AW-1:0] src     [NUM_SRCS];
  logic [REG_AW-1:0] dst     [NUM_STAGES];
  logic              we      [NUM_STAGES];
  logic [NUM_STAGES-1:0] hit [NUM_SRCS];
  fwd_sel_e          sel     [NUM_SRCS];
  logic              stall;

  assign src[0] = rs_i;
  assign src[1] = rt_i;
  assign dst[0] = ex_rd_i;
  assign dst[1] = mem_rd_i;
  assign dst[2] = wb_rd_i;
  assign we[0]  = ex_we_i;
  assign we[1]  = mem_we_i;
  assign we[2]  = wb_we_i;

  for (genvar s = 0; s < NUM_SRCS; s++) begin : g_src
    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
      fwd_match #(.REG_AW(REG_AW)) i_match (
        .src_i (src[s]),
        .dst_i (dst[k]),
        .we_i  (we[k]),
        .hit_o (hit[s][k])
      );
    end
    fwd_prio i_prio (
      .hit_i (hit[s]),
      .sel_o (sel[s])
    );
  end

  load_use_detect i_lud (
    .ex_load_i (ex_load_i),
    .sel_a_i   (sel[0]),
    .sel_b_i   (sel[1]),
    .stall_o   (stall)
  );

  assign fwd_a_o  = sel[0];
  assign fwd_b_o  = sel[1];
  assign stall_o  = stall;
  assign bubble_o = stall;

  always_comb begin
    if (stall_o) assert_stall_has_ex_fwd_R10: assert (fwd_a_o == 2'd1 || fwd_b_o == 2'd1);
    if (!ex_load_i) assert_no_stall_wo_load_R7: assert (!stall_o);
    if (fwd_a_o != 2'd0) assert_rs_nonzero_R6: assert (rs_i != '0);
    if (fwd_b_o != 2'd0) assert_rt_nonzero_R6: assert (rt_i != '0);
  end
endmodule

// File: tb/test_fwd_stall_unit.sv
module test_fwd_stall_unit;
  localparam int AW = 5;
  localparam int WATCHDOG_NS = 1_000_000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] rs, rt, ex_rd, mem_rd, wb_rd;
  logic ex_we, mem_we, wb_we, ex_load;
  logic [1:0] fwd_a, fwd_b;
  logic stall, bubble;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  fwd_stall_unit #(.REG_AW(AW)) i_fwd_stall_unit (
    .rs_i(rs), .rt_i(rt), .ex_rd_i(ex_rd), .mem_rd_i(mem_rd), .wb_rd_i(wb_rd),
    .ex_we_i(ex_we), .mem_we_i(mem_we), .wb_we_i(wb_we), .ex_load_i(ex_load),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .stall_o(stall), .bubble_o(bubble)
  );

  task automatic drive(input logic [AW-1:0] s, t, e, m, w,
                       input logic ew, mw, ww, ld);
    @(negedge clk);
    rs = s; rt = t; ex_rd = e; mem_rd = m; wb_rd = w;
    ex_we = ew; mem_we = mw; wb_we = ww; ex_load = ld;
  endtask

  task automatic expect_out(input string req, input logic [1:0] ea, eb, input logic es);
    @(posedge clk); #1;
    n_tests++;
    if (fwd_a !== ea || fwd_b !== eb || stall !== es || bubble !== es) begin
      n_fail++;
      $display("FAIL %s: a=%0d b=%0d stall=%0b bubble=%0b expected a=%0d b=%0d stall=%0b bubble=%0b",
               req, fwd_a, fwd_b, stall, bubble, ea, eb, es, es);
    end
  endtask

  task automatic t_idle;  // R1
    drive(5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 0, 0, 0, 0);
    expect_out("R1 idle", 2'd0, 2'd0, 1'b0);
    drive(5'd3, 5'd4, 5'd7, 5'd8, 5'd9, 1, 1, 1, 0);
    expect_out("R1 no match", 2'd0, 2'd0, 1'b0);
  endtask

  task automatic t_single_stage;  // R1
    drive(5'd3, 5'd0, 5'd3, 5'd8, 5'd9, 1, 1, 1, 0);
    expect_out("R1 ex", 2'd1, 2'd0, 1'b0);
    drive(5'd3, 5'd0, 5'd7, 5'd3, 5'd9, 1, 1, 1, 0);
    expect_out("R1 mem", 2'd2, 2'd0, 1'b0);
    drive(5'd3, 5'd0, 5'd7, 5'd8, 5'd3, 1, 1, 1, 0);
    expect_out("R1 wb", 2'd3, 2'd0, 1'b0);
  endtask

  task automatic t_priority;
    drive(5'd6, 5'd6, 5'd6, 5'd6, 5'd6, 1, 1, 1, 0);
    expect_out("R2 ex over all", 2'd1, 2'd1, 1'b0);
    drive(5'd6, 5'd6, 5'd2, 5'd6, 5'd6, 1, 1, 1, 0);
    expect_out("R3 mem over wb", 2'd2, 2'd2, 1'b0);
    drive(5'd6, 5'd6, 5'd6, 5'd6, 5'd6, 0, 1, 1, 0);
    expect_out("R3 ex disabled -> mem", 2'd2, 2'd2, 1'b0);
  endtask

  task automatic t_zero_src;  // R4
    drive(5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1, 1, 1, 1);
    expect_out("R4 zero src", 2'd0, 2'd0, 1'b0);
  endtask

  task automatic t_no_we;  // R5
    drive(5'd9, 5'd9, 5'd9, 5'd9, 5'd9, 0, 0, 0, 1);
    expect_out("R5 no write enable", 2'd0, 2'd0, 1'b0);
    drive(5'd9, 5'd9, 5'd9, 5'd9, 5'd9, 0, 0, 1, 0);
    expect_out("R5 only wb enabled", 2'd3, 2'd3, 1'b0);
  endtask

  task automatic t_independent;  // R6
    drive(5'd10, 5'd11, 5'd10, 5'd12, 5'd11, 1, 1, 1, 0);
    expect_out("R6 a ex b wb", 2'd1, 2'd3, 1'b0);
    drive(5'd12, 5'd10, 5'd10, 5'd12, 5'd11, 1, 1, 1, 0);
    expect_out("R6 a mem b ex", 2'd2, 2'd1, 1'b0);
  endtask

  task automatic t_load_use;  // R7 R8 R10
    drive(5'd12, 5'd15, 5'd12, 5'd1, 5'd2, 1, 1, 1, 1);
    expect_out("R7 load rs", 2'd1, 2'd0, 1'b1);
    drive(5'd13, 5'd12, 5'd12, 5'd1, 5'd2, 1, 1, 1, 1);
    expect_out("R8 load rt", 2'd0, 2'd1, 1'b1);
    drive(5'd12, 5'd13, 5'd4, 5'd12, 5'd13, 1, 1, 1, 1);
    expect_out("R7 load no ex match", 2'd2, 2'd3, 1'b0);
    // held instruction, then load advances with a bubble behind it
    drive(5'd12, 5'd12, 5'd12, 5'd5, 5'd6, 1, 1, 1, 1);
    expect_out("R10 stall cycle", 2'd1, 2'd1, 1'b1);
    drive(5'd12, 5'd12, 5'd0, 5'd12, 5'd5, 0, 1, 1, 0);
    expect_out("R10 recomputed", 2'd2, 2'd2, 1'b0);
  endtask

  task automatic t_load_two_behind;  // R9
    drive(5'd20, 5'd21, 5'd3, 5'd20, 5'd21, 1, 1, 1, 0);
    expect_out("R9 load in mem", 2'd2, 2'd3, 1'b0);
  endtask

  initial begin
    drive(5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 0, 0, 0, 0);
    t_idle();
    t_single_stage();
    t_priority();
    t_zero_src();
    t_no_we();
    t_independent();
    t_load_use();
    t_load_two_behind();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(WATCHDOG_NS);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule